// File: doc/BRIEF.md
# Bus Snoop Response Controller

This block sits on the snoop side of a processor's bus interface. For every snooped address tenure it looks at the transfer-type code and at the local state: the coherency state of the matching data-cache line, whether the matching instruction-cache line is valid, whether a reservation matches, and the progress of the local TLB-invalidate engine. From these it decides whether to answer with a retry pulse, a shared pulse, or both. It also issues the local actions the snoop calls for. These actions are a TLB-invalidate start, an instruction-cache line invalidate, or a write-back push of a modified line.

Retry rules for TLB-invalidate and synchronisation broadcasts avoid deadlock between processors. A snooped TLB invalidate is retried until the local invalidate has finished. It is ignored outright while the bus is retrying this processor's own TLB invalidate. A read that does not intend to cache, when it hits a Modified line, pushes the line to memory and demotes it to Exclusive instead of invalidating it. A small state machine holds the single outstanding push, protects its line against further snoops, and reports the Exclusive demotion when memory accepts the data.

The cache arrays, the TLB, arbitration and data movement are outside the block. They are reached through request/done and request/ack/fail handshakes.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: Responses (`rsp_artry`, `rsp_shd`) and the commands `tlbi_req` and `icinv_req` are single-cycle pulses registered one cycle after the cycle in which `snp_valid` is high, and never appear otherwise. Transfer-type codes other than 11000, 01000, 01001, 10000, 01101 and 01011 produce no response and no action.
- R2: A snooped TLB invalidate (code 11000) that arrives while `own_tlbi_in_retry` is high gets no response and starts no local invalidate.
- R3: Any other snooped TLB invalidate behaves in one of three ways. With nothing outstanding, it gets ARTRY and a `tlbi_req` pulse. While the local invalidate is pending (from `tlbi_req` until `tlbi_done`), it gets ARTRY only. The first TLB invalidate snooped after `tlbi_done` gets no response.
- R4: A snooped SYNC (01000) or TLBSYNC (01001) gets ARTRY while a local TLB invalidate is pending, and no response otherwise.
- R5: A snooped EIEIO (10000) gives no response and no action.
- R6: A snooped ICBI (01101) pulses `icinv_req` with `icinv_line` equal to the snooped line when `ic_line_valid` is high, and does nothing when it is low.
- R7: A read-with-no-intent-to-cache (01011) hitting a Modified line (`dc_state` 11) answers ARTRY and SHD together. It raises `push_req` from the next cycle with `push_line` equal to the snooped line, and holds it until `push_ack` or `push_fail`.
- R8: On `push_ack`, `push_req` drops and `dc_make_excl` pulses one cycle later with `push_line` still naming the pushed line. On `push_fail`, `push_req` drops and no demotion is signalled, so the line stays Modified.
- R9: A read-with-no-intent-to-cache that hits Exclusive (10) or Shared (01), or misses (Invalid, 00) with `resv_hit` low, gives no response and no action. A miss with `resv_hit` high gets SHD alone.
- R10: While a push is outstanding, an ICBI or read-with-no-intent-to-cache to the pushed line gets ARTRY only. A read-with-no-intent-to-cache hitting a Modified line elsewhere also gets ARTRY only and starts no second push.
- R11: During and straight after reset, every response and command output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Snooped address tenure present this cycle |
| snp_ttype | input | 5 | Transfer-type code of the snooped tenure |
| snp_line | input | LINE_W | Cache line index of the snooped address |
| dc_state | input | 2 | Data-cache state of the matching line: 00 I, 01 S, 10 E, 11 M |
| ic_line_valid | input | 1 | Matching instruction-cache line is valid |
| resv_hit | input | 1 | Snooped address matches an active reservation |
| own_tlbi_in_retry | input | 1 | The bus is currently retrying this processor's own TLB invalidate |
| rsp_artry | output | 1 | Address-retry response pulse |
| rsp_shd | output | 1 | Shared response pulse |
| tlbi_req | output | 1 | Start pulse to the local TLB-invalidate engine |
| tlbi_done | input | 1 | Local TLB invalidate has finished |
| icinv_req | output | 1 | Invalidate-instruction-cache-line pulse |
| icinv_line | output | LINE_W | Line to invalidate in the instruction cache |
| push_req | output | 1 | Write-back push of a Modified line requested |
| push_line | output | LINE_W | Line being pushed, also the line for the demotion |
| push_ack | input | 1 | Push completed, data accepted by memory |
| push_fail | input | 1 | Push abandoned |
| dc_make_excl | output | 1 | Pulse: demote `push_line` from Modified to Exclusive |

## Verification
The assertions watch, on every cycle, the timing relations. A response never appears without a snoop one cycle earlier, a TLB-invalidate start always comes with a retry, and a demotion only follows an acknowledged push. A failed push never leads to a demotion. They also check that SYNC under a pending invalidate is retried and that a snooped TLB invalidate during the processor's own retry stays silent. Only the bench's scenarios can show the full decision table and the multi-snoop sequences. The bench sweeps every transfer code against every cache state, instruction-cache valid and reservation value. It also walks the TLB invalidate through its retry, completion and consumption, and checks that snoops hitting the pushed line are held off.

// File: rtl/snp_pkg.sv
// Shared types for the snoop response controller.
// Assumes the 5-bit transfer-type codes and 2-bit coherency encoding below.
package snp_pkg;

    localparam int TT_W = 5;

    localparam logic [TT_W-1:0] TT_TLBI    = 5'b11000;
    localparam logic [TT_W-1:0] TT_SYNC    = 5'b01000;
    localparam logic [TT_W-1:0] TT_TLBSYNC = 5'b01001;
    localparam logic [TT_W-1:0] TT_EIEIO   = 5'b10000;
    localparam logic [TT_W-1:0] TT_ICBI    = 5'b01101;
    localparam logic [TT_W-1:0] TT_RDNC    = 5'b01011;

    typedef enum logic [1:0] {
        CS_INV  = 2'b00,
        CS_SHR  = 2'b01,
        CS_EXCL = 2'b10,
        CS_MOD  = 2'b11
    } coh_state_e;

    // Decision for one snooped tenure
    typedef struct packed {
        logic artry;
        logic shd;
        logic tlbi_start;
        logic tlbi_consume;
        logic icinv;
        logic push_start;
    } snp_act_t;

endpackage

// File: rtl/snp_decide.sv
// Combinational decision table for one snooped tenure.
// Assumes all state inputs are registered elsewhere; output is only
// meaningful while snp_valid is high (all zero otherwise).
module snp_decide
    import snp_pkg::*;
(
    input  logic            snp_valid,
    input  logic [TT_W-1:0] snp_ttype,
    input  coh_state_e      dc_state,
    input  logic            ic_line_valid,
    input  logic            resv_hit,
    input  logic            own_tlbi_in_retry,
    input  logic            tlbi_pend,
    input  logic            tlbi_cmpl,
    input  logic            push_busy,
    input  logic            line_match,
    output snp_act_t        act
);

    // Pick response and local action from transfer type and local state
    always_comb begin
        act = '0;
        if (snp_valid) begin
            if (push_busy && line_match &&
                (snp_ttype == TT_ICBI || snp_ttype == TT_RDNC)) begin
                act.artry = 1'b1;
            end else begin
                case (snp_ttype)
                    TT_TLBI: begin
                        if (!own_tlbi_in_retry) begin
                            if (tlbi_cmpl) begin
                                act.tlbi_consume = 1'b1;
                            end else if (tlbi_pend) begin
                                act.artry = 1'b1;
                            end else begin
                                act.artry      = 1'b1;
                                act.tlbi_start = 1'b1;
                            end
                        end
                    end
                    TT_SYNC, TT_TLBSYNC: begin
                        act.artry = tlbi_pend;
                    end
                    TT_ICBI: begin
                        act.icinv = ic_line_valid;
                    end
                    TT_RDNC: begin
                        case (dc_state)
                            CS_MOD: begin
                                act.artry = 1'b1;
                                if (!push_busy) begin
                                    act.shd        = 1'b1;
                                    act.push_start = 1'b1;
                                end
                            end
                            CS_INV:  act.shd = resv_hit;
                            default: act.shd = 1'b0;
                        endcase
                    end
                    // EIEIO and unlisted codes: no response, no action
                    default: act = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/snp_tlbi_track.sv
// Tracks the local TLB invalidate started on behalf of a snoop:
// pending from start until done, then a completion flag that the
// next snooped TLB invalidate consumes. Assumes tlbi_done only while pending.
module snp_tlbi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic consume,
    input  logic tlbi_done,
    output logic tlbi_req,
    output logic pend,
    output logic cmpl
);

    // Issue start pulse and hold the pending flag until the engine finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlbi_req <= 1'b0;
            pend     <= 1'b0;
        end else begin
            tlbi_req <= start;
            if (start)          pend <= 1'b1;
            else if (tlbi_done) pend <= 1'b0;
        end
    end

    // Remember completion until a retried TLB invalidate is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmpl <= 1'b0;
        else if (pend && tlbi_done) cmpl <= 1'b1;
        else if (consume)           cmpl <= 1'b0;
    end

    // R3
    tlbi_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlbi_req |=> !tlbi_req);

endmodule

// File: rtl/snp_push_fsm.sv
// Holds one outstanding write-back push of a Modified line and reports
// the demotion to Exclusive when memory acknowledges it. Assumes start
// is only given while idle and ack/fail only while pushing (ack wins).
module snp_push_fsm #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic              push_ack,
    input  logic              push_fail,
    output logic              push_req,
    output logic [LINE_W-1:0] push_line,
    output logic              dc_make_excl
);

    typedef enum logic {PS_IDLE, PS_BUSY} push_st_e;
    push_st_e st;

    // Step the push state and emit the demotion pulse on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= PS_IDLE;
            dc_make_excl <= 1'b0;
        end else begin
            dc_make_excl <= 1'b0;
            case (st)
                PS_IDLE: if (start) st <= PS_BUSY;
                PS_BUSY: begin
                    if (push_ack) begin
                        st           <= PS_IDLE;
                        dc_make_excl <= 1'b1;
                    end else if (push_fail) begin
                        st <= PS_IDLE;
                    end
                end
                default: st <= PS_IDLE;
            endcase
        end
    end

    // Latch the line being pushed
    always_ff @(posedge clk) begin
        if (!rst_n)                      push_line <= '0;
        else if (st == PS_IDLE && start) push_line <= start_line;
    end

    assign push_req = (st == PS_BUSY);

    // R8
    excl_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_make_excl |-> $past(push_req && push_ack));

    // R8
    fail_keeps_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_fail && !push_ack) |=> (!push_req && !dc_make_excl));

endmodule

// File: rtl/snoop_resp_ctrl.sv
// Snoop response controller: decides retry/shared responses for each
// snooped tenure and drives TLB-invalidate, instruction-cache invalidate
// and write-back push commands. Responses appear one cycle after snp_valid.
module snoop_resp_ctrl
    import snp_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [4:0]        snp_ttype,
    input  logic [LINE_W-1:0] snp_line,
    input  logic [1:0]        dc_state,
    input  logic              ic_line_valid,
    input  logic              resv_hit,
    input  logic              own_tlbi_in_retry,
    output logic              rsp_artry,
    output logic              rsp_shd,
    output logic              tlbi_req,
    input  logic              tlbi_done,
    output logic              icinv_req,
    output logic [LINE_W-1:0] icinv_line,
    output logic              push_req,
    output logic [LINE_W-1:0] push_line,
    input  logic              push_ack,
    input  logic              push_fail,
    output logic              dc_make_excl
);

    snp_act_t act;
    logic     tlbi_pend;
    logic     tlbi_cmpl;
    logic     line_match;

    assign line_match = (snp_line == push_line);

    snp_decide u_decide (
        .snp_valid         (snp_valid),
        .snp_ttype         (snp_ttype),
        .dc_state          (coh_state_e'(dc_state)),
        .ic_line_valid     (ic_line_valid),
        .resv_hit          (resv_hit),
        .own_tlbi_in_retry (own_tlbi_in_retry),
        .tlbi_pend         (tlbi_pend),
        .tlbi_cmpl         (tlbi_cmpl),
        .push_busy         (push_req),
        .line_match        (line_match),
        .act               (act)
    );

    snp_tlbi_track u_tlbi (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (act.tlbi_start),
        .consume   (act.tlbi_consume),
        .tlbi_done (tlbi_done),
        .tlbi_req  (tlbi_req),
        .pend      (tlbi_pend),
        .cmpl      (tlbi_cmpl)
    );

    snp_push_fsm #(.LINE_W(LINE_W)) u_push (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (act.push_start),
        .start_line   (snp_line),
        .push_ack     (push_ack),
        .push_fail    (push_fail),
        .push_req     (push_req),
        .push_line    (push_line),
        .dc_make_excl (dc_make_excl)
    );

    // Register the bus responses and the instruction-cache command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_artry  <= 1'b0;
            rsp_shd    <= 1'b0;
            icinv_req  <= 1'b0;
            icinv_line <= '0;
        end else begin
            rsp_artry <= act.artry;
            rsp_shd   <= act.shd;
            icinv_req <= act.icinv;
            if (act.icinv) icinv_line <= snp_line;
        end
    end

    // R1
    artry_follows_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_artry || rsp_shd) |-> $past(snp_valid));

    // R2
    own_retry_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ttype == TT_TLBI && own_tlbi_in_retry) |=> (!rsp_artry && !tlbi_req));

    // R3
    tlbi_start_retried_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlbi_req |-> rsp_artry);

    // R4
    sync_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_ttype == TT_SYNC || snp_ttype == TT_TLBSYNC) && tlbi_pend) |=> rsp_artry);

    // R6
    icinv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icinv_req |-> $past(snp_valid && snp_ttype == TT_ICBI && ic_line_valid));

    // R9
    shd_alone_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_shd && !rsp_artry) |-> $past(snp_valid && snp_ttype == TT_RDNC && dc_state == 2'b00 && resv_hit));

endmodule

// File: tb/test_snoop_resp_ctrl.sv
// Bench: sweeps all codes and local states from quiescent state, then
// directed sequences for TLB-invalidate retry and write-back push.
module test_snoop_resp_ctrl;

    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snp_valid = 1'b0;
    logic [4:0]    snp_ttype = '0;
    logic [LW-1:0] snp_line = '0;
    logic [1:0]    dc_state = '0;
    logic          ic_line_valid = 1'b0;
    logic          resv_hit = 1'b0;
    logic          own_tlbi_in_retry = 1'b0;
    logic          tlbi_done = 1'b0;
    logic          push_ack = 1'b0;
    logic          push_fail = 1'b0;
    logic          rsp_artry, rsp_shd, tlbi_req, icinv_req, push_req, dc_make_excl;
    logic [LW-1:0] icinv_line, push_line;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    snoop_resp_ctrl #(.LINE_W(LW)) i_snoop_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ttype(snp_ttype),
        .snp_line(snp_line), .dc_state(dc_state), .ic_line_valid(ic_line_valid),
        .resv_hit(resv_hit), .own_tlbi_in_retry(own_tlbi_in_retry),
        .rsp_artry(rsp_artry), .rsp_shd(rsp_shd), .tlbi_req(tlbi_req),
        .tlbi_done(tlbi_done), .icinv_req(icinv_req), .icinv_line(icinv_line),
        .push_req(push_req), .push_line(push_line), .push_ack(push_ack),
        .push_fail(push_fail), .dc_make_excl(dc_make_excl)
    );

    // {artry, shd, tlbi_req, icinv_req, push_req}
    function automatic logic [4:0] outv();
        return {rsp_artry, rsp_shd, tlbi_req, icinv_req, push_req};
    endfunction

    // Expected vector from quiescent state (nothing pending, no push)
    function automatic logic [4:0] exp_quiet(logic [4:0] tt, logic [1:0] st, logic icv, logic rs);
        case (tt)
            5'b11000: return 5'b10100;
            5'b01101: return {3'b000, icv, 1'b0};
            5'b01011: begin
                if (st == 2'b11) return 5'b11001;
                if (st == 2'b00 && rs) return 5'b01000;
                return 5'b00000;
            end
            default:  return 5'b00000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [LW+4:0] act, input logic [LW+4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One snoop; returns output vector sampled one cycle later
    task automatic snoop(input logic [4:0] tt, input logic [1:0] st, input logic icv,
                         input logic rs, input logic [LW-1:0] ln, output logic [4:0] v);
        @(negedge clk);
        snp_valid = 1'b1; snp_ttype = tt; dc_state = st;
        ic_line_valid = icv; resv_hit = rs; snp_line = ln;
        @(negedge clk);
        snp_valid = 1'b0;
        v = outv();
    endtask

    task automatic pulse_done();
        @(negedge clk); tlbi_done = 1'b1;
        @(negedge clk); tlbi_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [4:0] v;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 outputs in reset", {3'b0, outv(), dc_make_excl}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 outputs after reset", {3'b0, outv(), dc_make_excl}, '0);

        // R1 R5 R6 R7 R9 R3: full sweep from quiescent state
        for (int t = 0; t < 32; t++) begin
            for (int s = 0; s < 4; s++) begin
                for (int i = 0; i < 2; i++) begin
                    for (int r = 0; r < 2; r++) begin
                        logic [4:0] e;
                        e = exp_quiet(5'(t), 2'(s), i[0], r[0]);
                        snoop(5'(t), 2'(s), i[0], r[0], LW'(t * 4 + s), v);
                        chk($sformatf("R1/R5/R6/R7/R9 sweep tt=%b st=%b icv=%0d rs=%0d", 5'(t), 2'(s), i, r),
                            {3'b0, v, 1'b0}, {3'b0, e, 1'b0});
                        if (e[3] && !e[0])
                            chk("R9 shd alone", {3'b0, v, 1'b0}, {3'b0, 5'b01000, 1'b0});
                        if (e[1])
                            chk("R6 icinv_line", {5'b0, icinv_line}, {5'b0, LW'(t * 4 + s)});
                        if (e[0]) begin
                            chk("R7 push_line", {5'b0, push_line}, {5'b0, LW'(t * 4 + s)});
                            @(negedge clk); push_fail = 1'b1;
                            @(negedge clk); push_fail = 1'b0;
                            chk("R8 fail no demotion", {LW'(0), push_req, dc_make_excl, 3'b0}, '0);
                            @(negedge clk);
                            chk("R8 fail no demotion later", {LW'(0), dc_make_excl, 4'b0}, '0);
                        end
                        if (e[2]) begin
                            pulse_done();
                            snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
                            chk("R3 tlbi after done accepted", {3'b0, v, 1'b0}, '0);
                        end
                    end
                end
            end
        end

        // R3 R4 R2: TLB invalidate retry sequence
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R3 first tlbi", {3'b0, v, 1'b0}, {3'b0, 5'b10100, 1'b0});
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R3 tlbi while pending", {3'b0, v, 1'b0}, {3'b0, 5'b10000, 1'b0});
        snoop(5'b01000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R4 sync while pending", {3'b0, v, 1'b0}, {3'b0, 5'b10000, 1'b0});
        snoop(5'b01001, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R4 tlbsync while pending", {3'b0, v, 1'b0}, {3'b0, 5'b10000, 1'b0});
        snoop(5'b10000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R5 eieio while pending", {3'b0, v, 1'b0}, '0);
        own_tlbi_in_retry = 1'b1;
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R2 tlbi during own retry, pending", {3'b0, v, 1'b0}, '0);
        pulse_done();
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R2 tlbi during own retry, completed", {3'b0, v, 1'b0}, '0);
        own_tlbi_in_retry = 1'b0;
        snoop(5'b01000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R4 sync after done", {3'b0, v, 1'b0}, '0);
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R3 retried tlbi accepted", {3'b0, v, 1'b0}, '0);
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R3 new tlbi starts again", {3'b0, v, 1'b0}, {3'b0, 5'b10100, 1'b0});
        own_tlbi_in_retry = 1'b1;
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        own_tlbi_in_retry = 1'b0;
        pulse_done();
        snoop(5'b11000, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R3 consume after own retry", {3'b0, v, 1'b0}, '0);
        snoop(5'b01001, 2'b00, 1'b0, 1'b0, '0, v);
        chk("R4 tlbsync idle", {3'b0, v, 1'b0}, '0);

        // R7 R10 R8: push protection and acknowledge
        snoop(5'b01011, 2'b11, 1'b0, 1'b0, LW'(5), v);
        chk("R7 rdnc modified", {3'b0, v, 1'b0}, {3'b0, 5'b11001, 1'b0});
        snoop(5'b01101, 2'b00, 1'b1, 1'b0, LW'(5), v);
        chk("R10 icbi same line", {3'b0, v, 1'b0}, {3'b0, 5'b10001, 1'b0});
        snoop(5'b01011, 2'b10, 1'b0, 1'b0, LW'(5), v);
        chk("R10 rdnc same line", {3'b0, v, 1'b0}, {3'b0, 5'b10001, 1'b0});
        snoop(5'b01011, 2'b11, 1'b0, 1'b0, LW'(9), v);
        chk("R10 rdnc modified other line", {3'b0, v, 1'b0}, {3'b0, 5'b10001, 1'b0});
        snoop(5'b01101, 2'b00, 1'b1, 1'b0, LW'(9), v);
        chk("R6 icbi other line during push", {3'b0, v, 1'b0}, {3'b0, 5'b00011, 1'b0});
        chk("R7 push_line held", {5'b0, push_line}, {5'b0, LW'(5)});
        @(negedge clk); push_ack = 1'b1;
        @(negedge clk); push_ack = 1'b0;
        chk("R8 ack demotes", {3'b0, push_req, dc_make_excl, push_line, 3'b0},
            {3'b0, 1'b0, 1'b1, LW'(5), 3'b0});
        @(negedge clk);
        chk("R8 demotion single pulse", {LW'(0), dc_make_excl, 4'b0}, '0);
        snoop(5'b01101, 2'b00, 1'b1, 1'b0, LW'(5), v);
        chk("R6 icbi after push", {3'b0, v, 1'b0}, {3'b0, 5'b00010, 1'b0});
        snoop(5'b11111, 2'b11, 1'b1, 1'b1, LW'(5), v);
        chk("R1 unlisted code", {3'b0, v, 1'b0}, '0);
        @(negedge clk);
        chk("R1 no pulse without snoop", {3'b0, outv(), 1'b0}, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule